// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This block reads each of its two 64-bit operands as an 8x8 matrix of bits, one byte per row, and combines them as a matrix product. Row r of the first operand is paired with column c of the second operand. The two eight-bit vectors are ANDed together, and the eight products are then reduced by one of three rules. The rules are a GF(2) sum with an affine immediate constant, an OR of the products, or an AND of the products. A fourth operation returns the transpose of the first operand.

The datapath is purely combinational. A parameter can place an output register after it, and this register is present by default. The unit serves wide bit-level work such as bit permutation, affine transforms over GF(2^8) bytes, and reachability steps on small graphs. An operation select picks the rule applied in each cycle.

Top module: `bmat_unit`

## Requirements
- R1: With op_i = 2'b11 (transpose), bit c of result byte r equals bit r of byte c of a_i. Byte r means bits [8r+7:8r], and bit c is counted from the LSB.
- R2: With op_i = 2'b00 (XOR rule), result bit 8r+c equals imm_i[c] XOR the parity of (byte r of a_i AND v_c). Here v_c is column c of b_i: bit k of v_c is bit c of byte k of b_i.
- R3: Under the XOR rule with imm_i = 0 and b_i = 64'h8040201008040201 (the identity matrix), the result equals a_i.
- R4: With op_i = 2'b01 (OR rule), result bit 8r+c is 1 exactly when (byte r of a_i AND v_c) is nonzero, and is 0 otherwise.
- R5: With op_i = 2'b10 (AND rule), result bit 8r+c is 1 only when (byte r of a_i AND v_c) equals 8'hFF, and is 0 otherwise.
- R6: imm_i has no effect under the OR, AND and transpose rules, and b_i has no effect under transpose.
- R7: With OUT_REG = 1, res_o shows the result for the inputs present at the previous rising clock edge. While rst_n is low, res_o is 0.
- R8: Applying transpose to a transposed value returns the original value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 64 | First matrix; supplies the rows, or the value to transpose |
| b_i | input | 64 | Second matrix; supplies the columns |
| imm_i | input | 8 | Affine constant for the XOR rule, one bit per column |
| op_i | input | 2 | Rule select: 00 XOR, 01 OR, 10 AND, 11 transpose |
| res_o | output | 64 | Product or transpose result |

## Verification
The bound checker samples the inputs alongside the output register and tests several things on every cycle. It checks that a transpose matches its operand exactly, and that a zero second operand under the XOR rule yields the immediate repeated in every byte. It also checks that an OR-rule row is never set when its source row is zero, and that an AND-rule row is never set unless its source row is all ones. The bench's scenarios are needed for the full parity arithmetic across random matrices, the identity product and the round-trip transpose. They are also needed to show that the immediate and the second operand are truly ignored, and to confirm the reset value.

// File: rtl/bmat_pkg.sv
package bmat_pkg;
  typedef enum logic [1:0] {
    BM_XOR = 2'b00,
    BM_OR  = 2'b01,
    BM_AND = 2'b10,
    BM_TRN = 2'b11
  } bm_op_e;
endpackage

// File: rtl/bmat_flip.sv
module bmat_flip #(
  parameter int N = 8,
  localparam int W = N * N
) (
  input  logic [W-1:0] mat_i,
  output logic [W-1:0] mat_o
);
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign mat_o[r*N + c] = mat_i[c*N + r];
    end
  end
endmodule

// File: rtl/bmat_cell.sv
module bmat_cell
  import bmat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] row_i,
  input  logic [N-1:0] col_i,
  input  logic         aff_i,
  input  bm_op_e       op_i,
  output logic         bit_o
);
  logic [N-1:0] prod;

  assign prod = row_i & col_i;

  always_comb begin
    unique case (op_i)
      BM_XOR:  bit_o = aff_i ^ (^prod);
      BM_OR:   bit_o = |prod;
      BM_AND:  bit_o = &prod;
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bmat_unit.sv
module bmat_unit
  import bmat_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int W = N * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [N-1:0] imm_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] res_o
);
  bm_op_e       op;
  logic [W-1:0] a_flip;
  logic [W-1:0] b_flip;
  logic [W-1:0] prod_res;
  logic [W-1:0] res_next;

  assign op = bm_op_e'(op_i);

  // Transposed B: byte c holds column c of B.
  bmat_flip #(.N(N)) u_flip_b (.mat_i(b_i), .mat_o(b_flip));
  bmat_flip #(.N(N)) u_flip_a (.mat_i(a_i), .mat_o(a_flip));

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N; c++) begin : g_c
      bmat_cell #(.N(N)) u_cell (
        .row_i (a_i[r*N +: N]),
        .col_i (b_flip[c*N +: N]),
        .aff_i (imm_i[c]),
        .op_i  (op),
        .bit_o (prod_res[r*N + c])
      );
    end
  end

  always_comb begin
    res_next = (op == BM_TRN) ? a_flip : prod_res;
  end

  if (OUT_REG) begin : g_reg
    logic [W-1:0] res_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_next;
    end
    assign res_o = res_q;
  end else begin : g_comb
    assign res_o = res_next;
  end
endmodule

module bmat_unit_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int W = N * N
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [N-1:0] imm_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] res_o
);
  logic [W-1:0] s_a, s_b;
  logic [N-1:0] s_imm;
  logic [1:0]   s_op;
  logic [W-1:0] s_a_flip;

  if (OUT_REG) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_a <= '0; s_b <= '0; s_imm <= '0; s_op <= '0;
      end else begin
        s_a <= a_i; s_b <= b_i; s_imm <= imm_i; s_op <= op_i;
      end
    end
  end else begin : g_pass
    assign s_a = a_i;
    assign s_b = b_i;
    assign s_imm = imm_i;
    assign s_op = op_i;
  end

  for (genvar r = 0; r < N; r++) begin : g_fr
    for (genvar c = 0; c < N; c++) begin : g_fc
      assign s_a_flip[r*N + c] = s_a[c*N + r];
    end
  end

  // R1
  trn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == 2'b11) |-> (res_o == s_a_flip));

  // R2
  xor_zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == 2'b00 && s_b == '0) |-> (res_o == {N{s_imm}}));

  for (genvar r = 0; r < N; r++) begin : g_row_chk
    // R4
    or_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_op == 2'b01 && s_a[r*N +: N] == '0) |-> (res_o[r*N +: N] == '0));
    // R5
    and_row_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_op == 2'b10 && res_o[r*N +: N] != '0) |-> (&s_a[r*N +: N]));
  end
endmodule

bind bmat_unit bmat_unit_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
  .imm_i(imm_i), .op_i(op_i), .res_o(res_o)
);

// File: tb/bmat_unit_test.sv
module bmat_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [7:0]  imm_i = '0;
  logic [1:0]  op_i = '0;
  logic [63:0] res_o;
  int checks = 0, fails = 0;
  bit done = 0;

  bmat_unit uut (.clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
                 .imm_i(imm_i), .op_i(op_i), .res_o(res_o));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [7:0] imm, input logic [1:0] op);
    logic [63:0] r = '0;
    for (int row = 0; row < 8; row++) begin
      for (int col = 0; col < 8; col++) begin
        int ones = 0;
        for (int k = 0; k < 8; k++)
          if (a[row*8+k] && b[k*8+col]) ones++;
        case (op)
          2'b00: r[row*8+col] = imm[col] ^ ones[0];
          2'b01: r[row*8+col] = (ones != 0);
          2'b10: r[row*8+col] = (ones == 8);
          default: r[row*8+col] = a[col*8+row];
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at negedge, result registered at the next posedge, sample at the following negedge.
  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [7:0] imm, input logic [1:0] op);
    a_i = a; b_i = b; imm_i = imm; op_i = op;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, t, r1;
    logic [7:0] imm;
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    check("R7 reset", res_o, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 identity product
    a = {$urandom, $urandom};
    apply(a, 64'h8040201008040201, 8'h00, 2'b00);
    check("R3 identity", res_o, a);
    // R2 immediate applied per column
    apply(a, 64'h0, 8'hA5, 2'b00);
    check("R2 zero B gives imm", res_o, {8{8'hA5}});
    // R5 all ones
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'b10);
    check("R5 all ones", res_o, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(64'hFFFF_FFFF_FFFF_FF7F, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 2'b10);
    check("R5 one bit missing", res_o, 64'hFFFF_FFFF_FFFF_FF00);
    // R4 sparse
    apply(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0080, 8'hFF, 2'b01);
    check("R4 single link", res_o, 64'h80);
    // R1 directed
    apply(64'h0000_0000_0000_00FF, 64'h0, 8'h00, 2'b11);
    check("R1 row to column", res_o, 64'h0101_0101_0101_0101);
    // R8 round trip
    a = {$urandom, $urandom};
    apply(a, 64'h0, 8'h00, 2'b11);
    t = res_o;
    check("R1 transpose", t, model(a, 64'h0, 8'h0, 2'b11));
    apply(t, 64'h0, 8'h00, 2'b11);
    check("R8 double transpose", res_o, a);
    // R6 imm and B ignored
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    apply(a, b, 8'h00, 2'b01);
    r1 = res_o;
    apply(a, b, 8'hFF, 2'b01);
    check("R6 imm in OR", res_o, r1);
    apply(a, b, 8'h00, 2'b10);
    r1 = res_o;
    apply(a, b, 8'h3C, 2'b10);
    check("R6 imm in AND", res_o, r1);
    apply(a, b, 8'h00, 2'b11);
    r1 = res_o;
    apply(a, ~b, 8'h99, 2'b11);
    check("R6 B in transpose", res_o, r1);

    // Random mix, all rules (R2 R4 R5 R1); denser operands for AND rule
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      imm = 8'($urandom);
      op = 2'($urandom);
      if (op == 2'b10) begin
        a = a | {$urandom, $urandom} | {$urandom, $urandom};
        b = b | {$urandom, $urandom} | {$urandom, $urandom};
      end
      apply(a, b, imm, op);
      check(op == 2'b00 ? "R2 random" : op == 2'b01 ? "R4 random" :
            op == 2'b10 ? "R5 random" : "R1 random", res_o, model(a, b, imm, op));
    end

    // R7 reset clears output
    rst_n = 1'b0;
    #1;
    check("R7 async reset", res_o, 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule